// File: doc/BRIEF.md
# Countdown Watchdog Timer with Register Access

This block is a watchdog timer that software drives over a simple 32-bit register bus. A microsecond tick from outside goes into a programmable prescaler, which makes a slower count tick. Each count tick steps a countdown counter down by one. The counter is loaded from a load register.

Software keeps the system alive by writing a restart bit. That write reloads the counter and starts a new prescaler period. If software stops doing this while the watchdog is enabled, the counter runs out. The block then sends out a one-cycle system reset request, reloads the counter, and sets a sticky reset-cause flag.

The flag survives the system reset that the request triggers. It is cleared only by power-on reset or by software writing 1 to it. Software can therefore read it after the reset to learn that the watchdog caused it.

The block has two reset inputs:
- `por_n` is the power-on reset and clears everything.
- `sys_rst_n` is the system reset that the request leads to. It clears the control register, the load register and the counting state, and leaves the cause flag alone.

Top module: `wdt_timer`

## Requirements
- R1: After power-on reset the control register (offset 0x20) reads 0, the load register (offset 0x24) reads 0x0000FFFF and the status register (offset 0x00) reads 0.
- R2: The control register reads back the enable flag in bit 7 and the 16-bit prescale value in bits 31:16, with all other bits 0. The load register reads back its 16-bit value in bits 15:0 with the upper bits 0. A read returns its data on the clock edge that samples it, and the data holds until the next read.
- R3: Writing the status register with bit 9 set restarts the watchdog. The restart reloads the counter from the load register and clears the prescaler phase. Bit 9 always reads back 0. Status bits other than bit 1 ignore writes.
- R4: With prescale value P, one count tick comes every P microsecond ticks while enabled. P = 0 and P = 1 both give a count tick on every microsecond tick.
- R5: With load value L and an effective divide P, and a microsecond tick on every clock, the reset request rises exactly P*(L+1) clock edges after the restart edge. The request is high for one cycle.
- R6: After an expiry with no restart, the counter has been reloaded, so the next request follows P*(L+1) edges after the previous one.
- R7: Restarts written more often than the timeout produce no reset request.
- R8: While the enable bit is 0, the counter and the prescaler hold and no request is made. Setting the enable bit again resumes from the held state without an immediate request, so the expiry is delayed by exactly the number of disabled edges.
- R9: The reset-cause flag, readable as status bit 1, is set on the same edge that raises the reset request.
- R10: The cause flag stays set through `sys_rst_n`, while `sys_rst_n` returns the control and load registers to their reset values. Only `por_n` or a write of 1 to status bit 1 clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset, clears all state |
| sys_rst_n | input | 1 | Asynchronous active-low system reset, clears all state except the cause flag |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| wdt_rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The assertions check on every cycle that:
- no request appears while the watchdog is disabled;
- the counter holds while disabled;
- a restart loads the counter from the load register;
- the cause flag is set whenever the request is;
- the flag stays set unless a clear write or power-on reset removes it.

The bench scenarios show the exact expiry cycle for several prescale and load values, including divide-by-zero, the automatic reload period, the delay added by a disabled stretch, and suppression by regular restarts. They also show the register read-back and the flag surviving a system reset. Because these depend on counts over many cycles, the bench checks them against cycle stamps it computes itself.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned OFS_STATUS  = 32'h00;
   localparam int unsigned OFS_CTRL    = 32'h20;
   localparam int unsigned OFS_LOAD    = 32'h24;
   localparam int unsigned BIT_CAUSE   = 1;
   localparam int unsigned BIT_EN      = 7;
   localparam int unsigned BIT_RESTART = 9;
   localparam int unsigned PRESC_LSB   = 16;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LOAD_W    = 16,
   parameter int unsigned PRESC_W   = 16,
   parameter bit          REG_RDATA = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               por_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               fire,
   output logic               en_o,
   output logic [PRESC_W-1:0] presc_o,
   output logic [LOAD_W-1:0]  load_o,
   output logic               restart_o,
   output logic               cause_o
);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);

   logic              wr_en;
   logic              rd_en;
   logic [DATA_W-1:0] rd_mux;

   assign wr_en     = bus_sel & bus_wr;
   assign rd_en     = bus_sel & ~bus_wr;
   assign restart_o = wr_en && (bus_addr == A_STATUS) && bus_wdata[BIT_RESTART];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o    <= 1'b0;
         presc_o <= '0;
         load_o  <= '1;
      end else if (wr_en) begin
         if (bus_addr == A_CTRL) begin
            en_o    <= bus_wdata[BIT_EN];
            presc_o <= bus_wdata[PRESC_LSB +: PRESC_W];
         end
         if (bus_addr == A_LOAD) begin
            load_o <= bus_wdata[LOAD_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cause_o <= 1'b0;
      end else if (fire) begin
         cause_o <= 1'b1;
      end else if (wr_en && (bus_addr == A_STATUS) && bus_wdata[BIT_CAUSE]) begin
         cause_o <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         A_STATUS: rd_mux[BIT_CAUSE] = cause_o;
         A_CTRL: begin
            rd_mux[BIT_EN]                 = en_o;
            rd_mux[PRESC_LSB +: PRESC_W]   = presc_o;
         end
         A_LOAD:  rd_mux[LOAD_W-1:0] = load_o;
         default: rd_mux = '0;
      endcase
   end

   generate
      if (REG_RDATA) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= rd_mux;
         end
         assign bus_rdata = rd_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned PRESC_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               us_tick,
   input  logic               en,
   input  logic               restart,
   input  logic [PRESC_W-1:0] presc,
   output logic               tick_o
);
   logic [PRESC_W-1:0] phase;
   logic               last;

   assign last   = (presc <= PRESC_W'(1)) || (phase == presc - PRESC_W'(1));
   assign tick_o = en & us_tick & last & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (restart) begin
         phase <= '0;
      end else if (en && us_tick) begin
         phase <= last ? '0 : phase + PRESC_W'(1);
      end
   end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int unsigned LOAD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              tick,
   input  logic [LOAD_W-1:0] load,
   output logic [LOAD_W-1:0] cnt_o,
   output logic              fire_o,
   output logic              rst_req_o
);
   assign fire_o = tick && (cnt_o == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o     <= '1;
         rst_req_o <= 1'b0;
      end else begin
         rst_req_o <= fire_o;
         if (restart)     cnt_o <= load;
         else if (fire_o) cnt_o <= load;
         else if (tick)   cnt_o <= cnt_o - LOAD_W'(1);
      end
   end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LOAD_W    = 16,
   parameter int unsigned PRESC_W   = 16,
   parameter bit          REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              us_tick,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdt_rst_req
);
   initial begin
      assert (PRESC_LSB + PRESC_W <= DATA_W) else $fatal(1, "prescale field exceeds data width");
      assert (LOAD_W <= DATA_W && LOAD_W > 0) else $fatal(1, "bad load width");
      assert (BIT_RESTART < DATA_W && BIT_EN < PRESC_LSB) else $fatal(1, "bit layout overlaps");
      assert (ADDR_W >= 6) else $fatal(1, "address too narrow for register map");
   end

   logic               rst_n_all;
   logic               ctrl_en;
   logic [PRESC_W-1:0] presc_val;
   logic [LOAD_W-1:0]  load_val;
   logic [LOAD_W-1:0]  cnt_val;
   logic               restart;
   logic               cause;
   logic               cnt_tick;
   logic               fire;

   assign rst_n_all = por_n & sys_rst_n;

   wdt_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOAD_W(LOAD_W),
      .PRESC_W(PRESC_W), .REG_RDATA(REG_RDATA)
   ) i_regs (
      .clk(clk), .rst_n(rst_n_all), .por_n(por_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fire(fire),
      .en_o(ctrl_en), .presc_o(presc_val), .load_o(load_val),
      .restart_o(restart), .cause_o(cause)
   );

   wdt_prescaler #(.PRESC_W(PRESC_W)) i_presc (
      .clk(clk), .rst_n(rst_n_all), .us_tick(us_tick), .en(ctrl_en),
      .restart(restart), .presc(presc_val), .tick_o(cnt_tick)
   );

   wdt_countdown #(.LOAD_W(LOAD_W)) i_cnt (
      .clk(clk), .rst_n(rst_n_all), .restart(restart), .tick(cnt_tick),
      .load(load_val), .cnt_o(cnt_val), .fire_o(fire), .rst_req_o(wdt_rst_req)
   );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LOAD_W = 16
) (
   input logic              clk,
   input logic              por_n,
   input logic              rst_n_all,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              en,
   input logic              restart,
   input logic [LOAD_W-1:0] load,
   input logic [LOAD_W-1:0] cnt,
   input logic              cause,
   input logic              rst_req
);
   logic clr_wr;
   assign clr_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_STATUS)) && bus_wdata[BIT_CAUSE];

   AST_NO_FIRE_OFF: assert property (@(posedge clk) disable iff (!rst_n_all)
      !en |=> !rst_req); // R8
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n_all)
      (!en && !restart) |=> $stable(cnt)); // R8
   AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n_all)
      restart |=> (cnt == $past(load))); // R3
   AST_CAUSE_WITH_REQ: assert property (@(posedge clk) disable iff (!por_n)
      rst_req |-> cause); // R9
   AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      (cause && !clr_wr) |=> cause); // R10
endmodule

bind wdt_timer wdt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOAD_W(LOAD_W)) i_chk (
   .clk(clk), .por_n(por_n), .rst_n_all(rst_n_all),
   .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .en(ctrl_en), .restart(restart), .load(load_val), .cnt(cnt_val),
   .cause(cause), .rst_req(wdt_rst_req)
);

// File: tb/test_wdt_timer.sv
`timescale 1ns/1ps
module test_wdt_timer;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sys_rst_n = 1'b1;
   logic        us_tick = 1'b1;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdt_rst_req;

   int errs = 0;
   int checks = 0;
   int cyc = 0;
   int pulses = 0;
   bit done = 1'b0;
   int    exp_q[$];
   string tag_q[$];

   localparam logic [7:0] A_ST = 8'h00, A_CT = 8'h20, A_LD = 8'h24;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdt_timer i_wdt_timer (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .us_tick(us_tick),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d, output int edge_idx);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      edge_idx = cyc;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk);
      #1;
      bus_sel = 1'b0;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic expect_pulse(int at, string tag);
      exp_q.push_back(at);
      tag_q.push_back(tag);
   endtask

   task automatic wait_until(int c);
      while (cyc < c) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (por_n && wdt_rst_req) begin
         pulses++;
         checks++;
         if (exp_q.size() == 0) begin
            errs++;
            $display("FAIL R7/R8: unexpected reset request actual=%0d expected=none", cyc);
         end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e != cyc) begin
               errs++;
               $display("FAIL %s: pulse edge actual=%0d expected=%0d", t, cyc, e);
            end
         end
      end
   end

   task automatic finish_run();
      while (exp_q.size() != 0) begin
         checks++; errs++;
         $display("FAIL %s: pulse edge actual=none expected=%0d", tag_q.pop_front(), exp_q.pop_front());
      end
      $display("Result: errors=%0d of %0d checks", errs, checks);
      done = 1'b1;
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++; errs++;
         $display("FAIL watchdog: run hung actual=timeout expected=finish");
         finish_run();
      end
   end

   initial begin
      logic [31:0] d;
      int e0, ed, er, p0;
      repeat (3) @(posedge clk);
      #1 por_n = 1'b1;

      // R1 reset state
      chk("R1 out", {31'b0, wdt_rst_req}, 32'h0);
      rd(A_CT, d); chk("R1 ctrl", d, 32'h0);
      rd(A_LD, d); chk("R1 load", d, 32'h0000_FFFF);
      rd(A_ST, d); chk("R1 status", d, 32'h0);

      // R2 read-back
      wr(A_LD, 32'hFFFF_0003, e0);
      rd(A_LD, d); chk("R2 load", d, 32'h0000_0003);
      wr(A_CT, 32'h0004_FF7F, e0);
      rd(A_CT, d); chk("R2 ctrl en=0", d, 32'h0004_0000);
      wr(A_CT, 32'h0004_0080, e0);
      rd(A_CT, d); chk("R2 ctrl en=1", d, 32'h0004_0080);

      // R5 expiry, R6 auto reload, R9 cause
      wr(A_ST, 32'h0000_0200, e0);
      expect_pulse(e0 + 16, "R5");
      expect_pulse(e0 + 32, "R6");
      wait_until(e0 + 17);
      rd(A_ST, d); chk("R9 cause set", d, 32'h0000_0002);
      wait_until(e0 + 34);
      chk("R6 two pulses", exp_q.size(), 0);

      // R7 regular restarts suppress expiry
      wr(A_ST, 32'h0000_0200, e0);
      p0 = pulses;
      for (int k = 0; k < 6; k++) begin
         repeat (10) @(negedge clk);
         wr(A_ST, 32'h0000_0200, e0);
      end
      chk("R7 no pulse while kicked", pulses, p0);
      expect_pulse(e0 + 16, "R7 after kicks stop");
      wait_until(e0 + 18);

      // R8 disable holds count, resumes without immediate fire
      wr(A_ST, 32'h0000_0200, e0);
      repeat (5) @(negedge clk);
      wr(A_CT, 32'h0004_0000, ed);
      p0 = pulses;
      repeat (40) @(negedge clk);
      chk("R8 no pulse while off", pulses, p0);
      wr(A_CT, 32'h0004_0080, er);
      chk("R8 no immediate fire", {31'b0, wdt_rst_req}, 32'h0);
      expect_pulse(e0 + 16 + (er - ed), "R8 delayed expiry");
      wait_until(e0 + 18 + (er - ed));

      // R4 prescale 0 means divide by 1
      wr(A_LD, 32'h0000_0002, e0);
      wr(A_CT, 32'h0000_0080, e0);
      wr(A_ST, 32'h0000_0200, e0);
      expect_pulse(e0 + 3, "R4 prescale 0");
      wait_until(e0 + 3);
      wr(A_CT, 32'h0000_0000, ed);
      // R4 prescale 1
      wr(A_CT, 32'h0001_0080, e0);
      wr(A_ST, 32'h0000_0200, e0);
      expect_pulse(e0 + 3, "R4 prescale 1");
      wait_until(e0 + 3);
      wr(A_CT, 32'h0000_0000, ed);
      repeat (4) @(negedge clk);

      // R10 cause survives system reset
      @(negedge clk); sys_rst_n = 1'b0;
      repeat (2) @(negedge clk); sys_rst_n = 1'b1;
      rd(A_ST, d); chk("R10 cause kept", d, 32'h0000_0002);
      rd(A_CT, d); chk("R10 ctrl cleared", d, 32'h0);
      rd(A_LD, d); chk("R10 load cleared", d, 32'h0000_FFFF);

      // R3 restart reads 0, other status bits ignored
      wr(A_ST, 32'hFFFF_FFFD, e0);
      rd(A_ST, d); chk("R3 status write ignored", d, 32'h0000_0002);
      wr(A_ST, 32'h0000_0002, e0);
      rd(A_ST, d); chk("R10 cause cleared", d, 32'h0);

      // R3 restart reloads from load: restart mid count, then expiry from reload
      wr(A_LD, 32'h0000_0005, e0);
      wr(A_CT, 32'h0002_0080, e0);
      wr(A_ST, 32'h0000_0200, e0);
      repeat (6) @(negedge clk);
      wr(A_ST, 32'h0000_0200, e0);
      expect_pulse(e0 + 12, "R3 reload on restart");
      wait_until(e0 + 12);
      wr(A_CT, 32'h0000_0000, ed);
      repeat (4) @(negedge clk);

      // R10 power-on reset clears cause
      @(negedge clk); por_n = 1'b0;
      repeat (2) @(negedge clk); por_n = 1'b1;
      rd(A_ST, d); chk("R10 por clears cause", d, 32'h0);

      finish_run();
   end
endmodule